// File: doc/BRIEF.md
# Programmable-Priority DMA Channel Arbiter

This block decides which of five DMA channels owns the shared transfer bus. A channel bids for the bus when its enable bit is set and either its hardware request line or its software trigger bit is high. Software gives each channel a two-bit urgency level. The bidder with the largest level wins, and when levels are equal the channel with the lowest index wins.

The arbiter outputs a one-hot grant vector and a grant-valid flag. A grant stays in place until the owning channel reports that its transfer has finished by pulsing `xferDone` for one cycle. The grant drops on the next clock edge. The block picks the next owner one cycle later, so a running transfer is never pre-empted. Urgency levels are read only at the moment of arbitration. The data movement, address counters and bus protocol sit outside this block.

Top module: `dma_prio_arbiter`

## Requirements
- R1: Channel i (index 0 to 4, grant bit i) bids when `chEnable[i]` is 1 and either `hwReq[i]` or `swTrig[i]` is 1. A software trigger alone is enough to win the bus.
- R2: A channel whose `chEnable` bit is 0 is never granted, whatever its request and trigger inputs are.
- R3: The level of channel i is `prioLevel[2*i+1:2*i]`. The value 3 is the most urgent and 0 the least. Among the bidders, a channel with a strictly greater level wins.
- R4: When bidders share the greatest level, the lowest-indexed one among them wins.
- R5: `grant` has at most one bit set. It is all zeros when nothing is granted, and `grantValid` is 1 exactly when `grant` is nonzero.
- R6: When the arbiter is idle and a channel bids at a clock edge, the grant for the winner is visible right after that edge.
- R7: While a grant is held and `xferDone` is 0, the grant does not change, even if a more urgent channel starts to bid.
- R8: When `xferDone` is 1 at a clock edge while a grant is held, the grant clears at that edge. The next owner is chosen at the following edge.
- R9: Changing a channel's level while a grant is held does not change the current grant. The new level is used at the next arbitration.
- R10: A pulse on `xferDone` while nothing is granted has no effect, and a bid in the same cycle is still granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hwReq | input | 5 | Hardware request line of each channel |
| swTrig | input | 5 | Software trigger level of each channel |
| chEnable | input | 5 | Channel enable bits |
| prioLevel | input | 10 | Two-bit urgency level of each channel; channel i uses bits 2i+1:2i |
| xferDone | input | 1 | One-cycle strobe from the owning channel when its transfer ends |
| grant | output | 5 | One-hot bus grant |
| grantValid | output | 1 | High while a grant is held |

## Verification
The bench sets up ties, where a design that compares levels in the wrong direction or scans channels from the top would hand the bus to a higher index. It raises a more urgent bid in the middle of a transfer, which catches a design that re-arbitrates every cycle and pre-empts the owner. It also lowers the owner's level while the owner holds the bus, which exposes a design that checks levels against the live grant. Other cases catch a design that drops requests from disabled channels too late, one that ignores software triggers, and one that lets a stray done strobe block a grant arriving in the same cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // Strobes from the sequencing control into the grant datapath.
  typedef struct packed {
    logic load;   // capture the current winner into the grant register
    logic clear;  // release the held grant
  } arbStrobe_t;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int PRIO_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        hwReq,
  input  logic [NUM_CH-1:0]        swTrig,
  input  logic [NUM_CH-1:0]        chEnable,
  input  logic [NUM_CH*PRIO_W-1:0] prioLevel,
  input  arbStrobe_t               strobe,
  output logic                     anyEligible,
  output logic [NUM_CH-1:0]        grant
);
  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] winner;
  logic [PRIO_W-1:0] lvl [NUM_CH];
  logic [PRIO_W-1:0] bestLvl;
  logic              found;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gUnpack
      assign lvl[g] = prioLevel[g*PRIO_W +: PRIO_W];
    end
  endgenerate

  assign eligible    = (hwReq | swTrig) & chEnable;
  assign anyEligible = |eligible;

  // Ascending scan with a strict compare keeps the lowest index on ties.
  always_comb begin
    winner  = '0;
    bestLvl = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (eligible[i] && (!found || lvl[i] > bestLvl)) begin
        winner    = '0;
        winner[i] = 1'b1;
        bestLvl   = lvl[i];
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            grant <= '0;
    else if (strobe.load)  grant <= winner;
    else if (strobe.clear) grant <= '0;
  end
endmodule

// File: rtl/arb_control.sv
module arb_control
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       anyEligible,
  input  logic       xferDone,
  output arbStrobe_t strobe,
  output logic       busy
);
  always_comb begin
    strobe.load  = !busy && anyEligible;
    strobe.clear = busy && xferDone;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            busy <= 1'b0;
    else if (strobe.load)  busy <= 1'b1;
    else if (strobe.clear) busy <= 1'b0;
  end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int PRIO_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        hwReq,
  input  logic [NUM_CH-1:0]        swTrig,
  input  logic [NUM_CH-1:0]        chEnable,
  input  logic [NUM_CH*PRIO_W-1:0] prioLevel,
  input  logic                     xferDone,
  output logic [NUM_CH-1:0]        grant,
  output logic                     grantValid
);
  arbStrobe_t strobe;
  logic       anyEligible;

  arb_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .anyEligible(anyEligible),
    .xferDone(xferDone), .strobe(strobe), .busy(grantValid)
  );

  arb_datapath #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .hwReq(hwReq), .swTrig(swTrig),
    .chEnable(chEnable), .prioLevel(prioLevel), .strobe(strobe),
    .anyEligible(anyEligible), .grant(grant)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] hwReq,
  input logic [NUM_CH-1:0] swTrig,
  input logic [NUM_CH-1:0] chEnable,
  input logic              xferDone,
  input logic [NUM_CH-1:0] grant,
  input logic              grantValid
);
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r5_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid == (grant != '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && !xferDone) |=> (grantValid && $stable(grant)));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && xferDone) |=> !grantValid);

  a_r6_serve: assert property (@(posedge clk) disable iff (!rst_n)
    (!grantValid && ((hwReq | swTrig) & chEnable) != '0) |=> grantValid);

  a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grantValid) |-> ((grant & $past(chEnable & (hwReq | swTrig))) != '0));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!grantValid && ((hwReq | swTrig) & chEnable) == '0) |=> !grantValid);
endmodule

bind dma_prio_arbiter arb_checker #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_dma_prio_arbiter.sv
`timescale 1ns/1ps
module sim_dma_prio_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] hwReq = '0, swTrig = '0, chEnable = '0;
  logic [9:0] prioLevel = '0;
  logic       xferDone = 1'b0;
  logic [4:0] grant;
  logic       grantValid;
  int         testCount = 0, failCount = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  dma_prio_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .hwReq(hwReq), .swTrig(swTrig),
    .chEnable(chEnable), .prioLevel(prioLevel), .xferDone(xferDone),
    .grant(grant), .grantValid(grantValid)
  );

  function automatic logic [9:0] lv(input int l0, l1, l2, l3, l4);
    return {l4[1:0], l3[1:0], l2[1:0], l1[1:0], l0[1:0]};
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    testCount++;
    if (act !== exp || grantValid !== (exp != '0)) begin
      failCount++;
      $display("FAIL %s: grant=%b valid=%b expected grant=%b", tag, act, grantValid, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // End the current grant and return to an idle, empty state.
  task automatic finishXfer(input string tag);
    hwReq = '0; swTrig = '0; xferDone = 1'b1;
    step();
    xferDone = 1'b0;
    chk({tag, " R8 release"}, grant, 5'b00000);
    step();
  endtask

  task automatic tReset();
    chk("R5 reset", grant, 5'b00000);
  endtask

  task automatic tSingle();
    chEnable = '1; prioLevel = lv(0,0,0,0,0); hwReq = 5'b00100;
    step();
    chk("R1 R6 hw req ch2", grant, 5'b00100);
    finishXfer("single");
    swTrig = 5'b10000;
    step();
    chk("R1 sw trig ch4", grant, 5'b10000);
    finishXfer("swtrig");
  endtask

  task automatic tDisabled();
    chEnable = 5'b00000; hwReq = 5'b11111; swTrig = 5'b11111;
    step(); step();
    chk("R2 all disabled", grant, 5'b00000);
    chEnable = 5'b01000; prioLevel = lv(3,3,3,0,3);
    step();
    chk("R2 only ch3 enabled", grant, 5'b01000);
    chEnable = '1;
    finishXfer("disabled");
  endtask

  task automatic tPriority();
    prioLevel = lv(0,1,0,3,2); hwReq = 5'b11010;
    step();
    chk("R3 highest level ch3", grant, 5'b01000);
    finishXfer("prio");
    prioLevel = lv(1,0,2,0,3); swTrig = 5'b10101;
    step();
    chk("R3 level3 on ch4", grant, 5'b10000);
    finishXfer("prio2");
  endtask

  task automatic tTie();
    prioLevel = lv(1,0,2,0,2); hwReq = 5'b10101;
    step();
    chk("R4 tie ch2 over ch4", grant, 5'b00100);
    finishXfer("tie");
    prioLevel = lv(3,3,3,3,3); hwReq = 5'b11110; swTrig = 5'b00001;
    step();
    chk("R4 full tie ch0", grant, 5'b00001);
    finishXfer("tie2");
  endtask

  task automatic tHold();
    prioLevel = lv(3,0,0,0,0); hwReq = 5'b10000;
    step();
    chk("R7 grant ch4", grant, 5'b10000);
    hwReq = 5'b00001;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R7 no preemption", grant, 5'b10000);
    end
    xferDone = 1'b1;
    step();
    xferDone = 1'b0;
    chk("R8 cleared on done", grant, 5'b00000);
    step();
    chk("R8 rearbitrated ch0", grant, 5'b00001);
    finishXfer("hold");
  endtask

  task automatic tPrioChange();
    prioLevel = lv(0,3,2,0,0); hwReq = 5'b00110;
    step();
    chk("R9 ch1 wins", grant, 5'b00010);
    prioLevel = lv(0,0,2,0,0);
    step(); step();
    chk("R9 held after level change", grant, 5'b00010);
    xferDone = 1'b1;
    step();
    xferDone = 1'b0;
    chk("R8 cleared", grant, 5'b00000);
    step();
    chk("R9 new level applied ch2", grant, 5'b00100);
    finishXfer("chg");
  endtask

  task automatic tStrayDone();
    xferDone = 1'b1;
    step();
    chk("R10 stray done idle", grant, 5'b00000);
    hwReq = 5'b01000;
    step();
    xferDone = 1'b0;
    chk("R10 grant despite done", grant, 5'b01000);
    finishXfer("stray");
  endtask

  initial begin
    #100000;
    if (!finished) begin
      failCount++; testCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    step(); step();
    tReset();
    rst_n = 1'b1;
    step();
    tReset();
    tSingle();
    tDisabled();
    tPriority();
    tTie();
    tHold();
    tPrioChange();
    tStrayDone();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule